// File: doc/BRIEF.md
# Wide Integer Multiplier with Rotating Lane Schedule

This block forms the full double-width product of two wide unsigned operands, 256 bits each by default, giving a 512-bit result. Each operand is cut into 16-bit half-words. Half-word 2w is the low half of 32-bit word w, and half-word 2w+1 is its high half. Sixteen multiply-accumulate lanes, each 16x16, work in parallel on a rotating schedule. One pass over the half-words of the second operand leaves 31 partial sums, each 47 bits wide.

A second phase folds the partial sums into 32-bit product words, one word per cycle. In each cycle it adds the even partial sum in full. It also adds the upper part of the odd partial sum just below it, and the low 16 bits of the odd partial sum just above it, shifted up by 16. A carry several bits wide moves from one word to the next.

The block takes its operands as parallel buses together with a one-cycle start strobe. When the last product word is written, it raises a one-cycle done flag. The block does no modular reduction.

Top module: `mpa_mul`

## Requirements
- R1: After reset, `done` is low and `product` is all zeros.
- R2: When an operation completes, `product` equals the full unsigned product `a_in * b_in` of the operands accepted at start. Bit 16h of an operand bus is the least significant bit of half-word h.
- R3: `done` is high for exactly one cycle. It rises 2*N_HALF clock edges after the edge that accepts `start`, which is 32 edges with the default parameters.
- R4: `product` does not change after `done` until the fold phase of the next accepted operation. This holds through idle cycles and through the whole multiply phase of the next operation.
- R5: A `start` pulse that arrives while an operation is in progress is ignored. The running operation still completes at its original time with its original result, and no further `done` follows.
- R6: The operands are captured on the accepting edge. Later changes on `a_in` and `b_in` have no effect on the running result.
- R7: A `start` held high in the cycle where `done` is high is accepted. It begins a new operation, whose `done` arrives 2*N_HALF edges later.
- R8: The extreme operands give exact results. Zero times anything gives zero. All-ones times all-ones gives 2^512 - 2^257 + 1, which drives the largest carries through the fold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; accepted only when the block is idle |
| a_in | input | 256 | First operand, sixteen 16-bit half-words, half-word 0 in the least significant bits |
| b_in | input | 256 | Second operand, same layout |
| product | output | 512 | Full product, sixteen 32-bit words, word 0 in the least significant bits |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The hardest behaviours to reach are the ones tied to timing rather than to data. A strobe can land in the middle of the multiply phase, or in exactly the cycle where the previous result completes. The operand buses can also change while the lanes are still reading the captured half-words. The bench reaches these cases by counting falling edges from the accepting edge. It places the strobe, or the bus change, at a chosen cycle, and then checks both the arrival time of `done` and the product it carries. Carries in the fold phase are pushed to their maximum with all-ones operands. Single non-zero half-words at both ends of each operand confirm the rotation and the half-word ordering.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_MUL  = 2'd1,
      PH_FOLD = 2'd2
   } phase_e;

endpackage

// File: rtl/mpa_ctrl.sv
module mpa_ctrl
   import mpa_pkg::*;
#(
   parameter int N_HALF = 16,
   localparam int CNT_W = $clog2(N_HALF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] step_o,
   output logic             accept_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_HALF - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] step_q;
   logic             done_q;

   assign accept_o = start_i && (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_MUL;
                  step_q  <= '0;
               end
            end
            PH_MUL: begin
               if (step_q == LAST) begin
                  phase_q <= PH_FOLD;
                  step_q  <= '0;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            PH_FOLD: begin
               if (step_q == LAST) begin
                  phase_q <= PH_IDLE;
                  step_q  <= '0;
                  done_q  <= 1'b1;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               step_q  <= '0;
            end
         endcase
      end
   end

   assign phase_o = phase_q;
   assign step_o  = step_q;
   assign done_o  = done_q;

   // R3: completion flag is a single-cycle pulse
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R3: the multiply phase advances one step per cycle
   a_r3_mul_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_MUL && step_q != LAST) |=>
         (phase_q == PH_MUL && step_q == $past(step_q) + 1'b1));

   // R3: the fold phase follows the last multiply step
   a_r3_fold_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_MUL && step_q == LAST) |=> (phase_q == PH_FOLD && step_q == '0));

   // R5: a strobe while busy does not end or restart the operation
   a_r5_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && phase_q != PH_IDLE && !(phase_q == PH_FOLD && step_q == LAST)) |=>
         (phase_q != PH_IDLE));

endmodule

// File: rtl/mpa_mac_lane.sv
module mpa_mac_lane #(
   parameter int HALF_W = 16,
   parameter int ACC_W  = 47,
   parameter int N_HALF = 16,
   localparam int WORD_W = 2 * HALF_W,
   localparam int HEAD_W = WORD_W + $clog2(N_HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              en_i,
   input  logic              dump_i,
   input  logic [HALF_W-1:0] a_h_i,
   input  logic [HALF_W-1:0] b_h_i,
   output logic [ACC_W-1:0]  acc_o
);

   logic [WORD_W-1:0] mul_w;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  base_w;

   assign mul_w  = {{HALF_W{1'b0}}, a_h_i} * {{HALF_W{1'b0}}, b_h_i};
   assign base_w = dump_i ? '0 : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear_i) begin
         acc_q <= '0;
      end else if (en_i) begin
         acc_q <= base_w + ACC_W'(mul_w);
      end
   end

   assign acc_o = acc_q;

   // R2: at most N_HALF products are ever summed, so headroom bits stay clear
   a_r2_lane_headroom: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[ACC_W-1:HEAD_W] == '0);

endmodule

// File: rtl/mpa_fold.sv
module mpa_fold #(
   parameter int HALF_W = 16,
   parameter int ACC_W  = 47,
   parameter int N_HALF = 16,
   localparam int WORD_W  = 2 * HALF_W,
   localparam int N_PART  = 2 * N_HALF - 1,
   localparam int CNT_W   = $clog2(N_HALF),
   localparam int CARRY_W = ACC_W - WORD_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clear_i,
   input  logic                               en_i,
   input  logic [CNT_W-1:0]                   step_i,
   input  logic [N_PART-1:0][ACC_W-1:0]       part_i,
   output logic [N_HALF-1:0][WORD_W-1:0]      prod_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_HALF - 1);

   logic [N_HALF-1:0][WORD_W-1:0] prod_q;
   logic [CARRY_W-1:0]            carry_q;

   logic [CNT_W:0]     idx_even, idx_prev, idx_next;
   logic               first_w, last_w;
   logic [HALF_W-1:0]  next_low;
   logic [ACC_W-1:0]   even_v, prev_v, next_v, cw0, cw1, sum_v;

   always_comb begin
      first_w  = (step_i == '0);
      last_w   = (step_i == LAST);
      idx_even = {step_i, 1'b0};
      idx_prev = first_w ? idx_even + 1'b1 : idx_even - 1'b1;
      idx_next = last_w  ? idx_even - 1'b1 : idx_even + 1'b1;
      even_v   = part_i[idx_even];
      prev_v   = first_w ? '0 : (part_i[idx_prev] >> HALF_W);
      next_low = part_i[idx_next][HALF_W-1:0];
      next_v   = last_w ? '0 : ACC_W'({next_low, {HALF_W{1'b0}}});
      cw0      = even_v + prev_v;
      cw1      = next_v | ACC_W'(carry_q);
      sum_v    = cw0 + cw1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q  <= '0;
         carry_q <= '0;
      end else if (clear_i) begin
         carry_q <= '0;
      end else if (en_i) begin
         prod_q[step_i] <= sum_v[WORD_W-1:0];
         carry_q        <= sum_v[ACC_W-1:WORD_W];
      end
   end

   assign prod_o = prod_q;

   // R2: the product fits its width, so nothing is carried out of the top word
   a_r2_top_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && last_w) |-> (sum_v[ACC_W-1:WORD_W] == '0));

   // R4: product words change only during the fold phase
   a_r4_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(prod_q));

endmodule

// File: rtl/mpa_mul.sv
module mpa_mul
   import mpa_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int N_HALF = 16,
   parameter int ACC_W  = 47,
   localparam int OP_W   = HALF_W * N_HALF,
   localparam int WORD_W = 2 * HALF_W,
   localparam int PROD_W = 2 * OP_W,
   localparam int N_PART = 2 * N_HALF - 1,
   localparam int CNT_W  = $clog2(N_HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   a_in,
   input  logic [OP_W-1:0]   b_in,
   output logic [PROD_W-1:0] product,
   output logic              done
);

   if (N_HALF < 2 || (N_HALF & (N_HALF - 1)) != 0) begin : g_bad_count
      $error("mpa_mul: N_HALF must be a power of two of at least 2");
   end
   if (ACC_W < WORD_W + CNT_W + 2) begin : g_bad_acc
      $error("mpa_mul: ACC_W too narrow for lane sums and fold carries");
   end
   if (HALF_W < 2) begin : g_bad_half
      $error("mpa_mul: HALF_W must be at least 2");
   end

   phase_e           phase;
   logic [CNT_W-1:0] step;
   logic             accept;

   logic [N_HALF-1:0][HALF_W-1:0] a_q, b_q;
   logic [N_HALF-1:0][ACC_W-1:0]  acc;
   logic [N_HALF-2:0][ACC_W-1:0]  part_hi_q;
   logic [N_PART-1:0][ACC_W-1:0]  part_all;
   logic [N_HALF-1:0][WORD_W-1:0] prod_words;
   logic [HALF_W-1:0]             b_sel;
   logic                          mul_en;

   mpa_ctrl #(.N_HALF(N_HALF)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .phase_o  (phase),
      .step_o   (step),
      .accept_o (accept),
      .done_o   (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (accept) begin
         a_q <= a_in;
         b_q <= b_in;
      end
   end

   assign mul_en = (phase == PH_MUL);
   assign b_sel  = b_q[CNT_W'(N_HALF - 1) - step];

   for (genvar x = 0; x < N_HALF; x++) begin : g_lane
      logic [CNT_W-1:0]  a_idx;
      logic              dump;
      assign a_idx = step - CNT_W'(x);
      if (x == 0) begin : g_nodump
         assign dump = 1'b0;
      end else begin : g_dump
         assign dump = (step == CNT_W'(x));
      end
      mpa_mac_lane #(.HALF_W(HALF_W), .ACC_W(ACC_W), .N_HALF(N_HALF)) lane_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (accept),
         .en_i    (mul_en),
         .dump_i  (dump),
         .a_h_i   (a_q[a_idx]),
         .b_h_i   (b_sel),
         .acc_o   (acc[x])
      );
   end

   // Upper partial sums: lane t is unloaded in cycle t to slot N_HALF-1-t.
   for (genvar j = 0; j < N_HALF - 1; j++) begin : g_part_hi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            part_hi_q[j] <= '0;
         end else if (mul_en && step == CNT_W'(N_HALF - 1 - j)) begin
            part_hi_q[j] <= acc[N_HALF - 1 - j];
         end
      end
   end

   // Lower partial sums are read straight from the idle accumulators.
   for (genvar k = 0; k < N_PART; k++) begin : g_part_map
      if (k < N_HALF) begin : g_lo
         assign part_all[k] = acc[N_HALF - 1 - k];
      end else begin : g_hi
         assign part_all[k] = part_hi_q[k - N_HALF];
      end
   end

   mpa_fold #(.HALF_W(HALF_W), .ACC_W(ACC_W), .N_HALF(N_HALF)) fold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .en_i    (phase == PH_FOLD),
      .step_i  (step),
      .part_i  (part_all),
      .prod_o  (prod_words)
   );

   assign product = prod_words;

   // R6: captured operands stay fixed while an operation runs
   a_r6_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(a_q) && $stable(b_q));

endmodule

// File: tb/mpa_mul_tb.sv
`timescale 1ns/1ps
module mpa_mul_tb_top;

   localparam int OP_W   = 256;
   localparam int PROD_W = 512;
   localparam int LAT    = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [OP_W-1:0]   a_in = '0;
   logic [OP_W-1:0]   b_in = '0;
   logic [PROD_W-1:0] product;
   logic              done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   mpa_mul dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .a_in    (a_in),
      .b_in    (b_in),
      .product (product),
      .done    (done)
   );

   function automatic logic [PROD_W-1:0] ref_mul(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
      logic [PROD_W-1:0] wa, wb;
      wa = {{OP_W{1'b0}}, a};
      wb = {{OP_W{1'b0}}, b};
      return wa * wb;
   endfunction

   function automatic logic [OP_W-1:0] rnd_op();
      logic [OP_W-1:0] r;
      for (int i = 0; i < OP_W / 32; i++) r[i*32 +: 32] = $urandom();
      return r;
   endfunction

   task automatic check(bit ok, string req, logic [PROD_W-1:0] act, logic [PROD_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive a start at a falling edge; returns after the accepting edge.
   task automatic launch(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
      start = 1'b1;
      a_in  = a;
      b_in  = b;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!done && cyc < 200);
   endtask

   task automatic run_op(logic [OP_W-1:0] a, logic [OP_W-1:0] b, string req);
      int cyc;
      logic [PROD_W-1:0] exp;
      exp = ref_mul(a, b);
      @(negedge clk);
      launch(a, b);
      wait_done(cyc);
      check(cyc == LAT, "R3 latency", PROD_W'(cyc), PROD_W'(LAT));
      check(product == exp, req, product, exp);
      @(negedge clk);
      check(done == 1'b0, "R3 single-cycle done", PROD_W'(done), '0);
   endtask

   task automatic t_reset();
      check(done == 1'b0, "R1 done after reset", PROD_W'(done), '0);
      check(product == '0, "R1 product after reset", product, '0);
   endtask

   task automatic t_extremes();
      logic [OP_W-1:0] ones;
      logic [PROD_W-1:0] exp;
      ones = '1;
      run_op('0, rnd_op(), "R8 zero times random");
      exp = '0;
      exp = exp - (PROD_W'(1) << 257) + PROD_W'(1);
      @(negedge clk);
      launch(ones, ones);
      begin
         int cyc;
         wait_done(cyc);
         check(product == exp, "R8 all-ones squared", product, exp);
      end
   endtask

   task automatic t_halfword_walk();
      run_op(OP_W'(1), OP_W'(1), "R2 lowest half-words");
      run_op(OP_W'(1) << 240, OP_W'(1) << 240, "R2 highest half-words");
      run_op(OP_W'(16'hFFFF) << 16, OP_W'(16'hABCD) << 112, "R2 odd half-word ordering");
      run_op(OP_W'(16'h8001) << 48, OP_W'(16'hFFFF) << 208, "R2 mixed half-words");
   endtask

   task automatic t_random();
      for (int i = 0; i < 6; i++) run_op(rnd_op(), rnd_op(), "R2 random operands");
   endtask

   task automatic t_hold();
      logic [PROD_W-1:0] held;
      logic [OP_W-1:0] a2, b2;
      held = product;
      repeat (7) @(negedge clk);
      check(product == held, "R4 hold while idle", product, held);
      a2 = rnd_op();
      b2 = rnd_op();
      launch(a2, b2);
      repeat (LAT / 2 - 1) @(negedge clk);
      check(product == held, "R4 hold through next multiply phase", product, held);
      begin
         int cyc;
         wait_done(cyc);
         check(product == ref_mul(a2, b2), "R4 new product after fold", product, ref_mul(a2, b2));
      end
   endtask

   task automatic t_busy_start();
      logic [OP_W-1:0] a1, b1;
      int cyc, extra;
      a1 = rnd_op();
      b1 = rnd_op();
      @(negedge clk);
      launch(a1, b1);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (cyc == 4) begin
            start = 1'b1;
            a_in = rnd_op();
            b_in = rnd_op();
         end
         if (cyc == 5) start = 1'b0;
         if (cyc == 20) start = 1'b1;
         if (cyc == 21) start = 1'b0;
      end while (!done && cyc < 200);
      check(cyc == LAT, "R5 done time unchanged by busy start", PROD_W'(cyc), PROD_W'(LAT));
      check(product == ref_mul(a1, b1), "R5 result of first operands", product, ref_mul(a1, b1));
      extra = 0;
      repeat (2 * LAT) begin
         @(negedge clk);
         if (done) extra++;
      end
      check(extra == 0, "R5 no further done", PROD_W'(extra), '0);
   endtask

   task automatic t_operand_change();
      logic [OP_W-1:0] a1, b1;
      int cyc;
      a1 = rnd_op();
      b1 = rnd_op();
      @(negedge clk);
      launch(a1, b1);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (cyc == 3) begin
            a_in = rnd_op();
            b_in = '1;
         end
         if (cyc == 20) a_in = '0;
      end while (!done && cyc < 200);
      check(product == ref_mul(a1, b1), "R6 bus changes ignored", product, ref_mul(a1, b1));
   endtask

   task automatic t_back_to_back();
      logic [OP_W-1:0] a2, b2;
      int cyc;
      run_op(rnd_op(), rnd_op(), "R2 first of pair");
      a2 = rnd_op();
      b2 = rnd_op();
      @(negedge clk);
      launch(rnd_op(), rnd_op());
      wait_done(cyc);
      // done is high now: start in this same cycle
      launch(a2, b2);
      wait_done(cyc);
      check(cyc == LAT, "R7 start during done accepted", PROD_W'(cyc), PROD_W'(LAT));
      check(product == ref_mul(a2, b2), "R7 product of chained op", product, ref_mul(a2, b2));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_extremes();
      t_halfword_walk();
      t_random();
      t_hold();
      t_busy_start();
      t_operand_change();
      t_back_to_back();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule